// File: doc/BRIEF.md
# Freezable Down-Counting Timer with Event Latch

This block is a 32-bit down-counter that steps once per timebase tick and flags a timer event each time it borrows past zero. Software loads a start value, reads the live count, and works an event latch through a mask register and an acknowledge strobe. The latch also collects events from a generic set of other sources.

The block has one unusual rule. If the timer event is acknowledged while its mask bit is clear, the counter stops at its present value. Later ticks, and later mask changes, leave it stopped. Only a fresh load starts it again. The out-of-reset count is either zero or the bitwise inverse of the low timebase word, selected by an option input. A system can use the second choice to line the counter up with a free-running timebase.

Top module: `freeze_dec_timer`

## Requirements
- R1: While reset (rst_n low) is sampled, the count becomes the bitwise inverse of timebase_lo when sync_opt is 1, and zero otherwise. The pending, mask and frozen outputs clear.
- R2: A load_en strobe puts load_data into count on the following edge and clears frozen.
- R3: While running, each tick_en strobe lowers count by exactly one. Cycles without a tick leave the count unchanged.
- R4: A tick at count zero wraps the count to 32'hFFFFFFFF and sets the timer event, which is pending bit 0, on that same edge. The same thing happens at every later pass through zero.
- R5: An ack_en strobe clears exactly the pending bits that are set in ack_data. Events that arrive in the same cycle are collected first, so an acknowledged bit ends up clear.
- R6: An acknowledge with bit 0 set, while mask bit 0 is clear and the counter is running, sets frozen and holds the count at its value from that cycle.
- R7: While frozen, ticks change nothing and no timer event is raised.
- R8: A mask write does not clear frozen. Only a load does.
- R9: When load_en and tick_en arrive in the same cycle, the count takes load_data and the tick is dropped.
- R10: ext_evt bits set the matching pending bits. evt_avail is high whenever some pending bit has its mask bit set, including right after an acknowledge.
- R11: A load never clears pending bits, so a timer event raised just before a load remains pending.
- R12: An acknowledge of bit 0 while mask bit 0 is set does not freeze the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_opt | input | 1 | Selects the reset count: 1 gives the inverted timebase, 0 gives zero |
| timebase_lo | input | 32 | Low word of the system timebase |
| tick_en | input | 1 | One-cycle timebase tick |
| load_en | input | 1 | One-cycle load strobe |
| load_data | input | 32 | Value to load |
| ack_en | input | 1 | One-cycle acknowledge strobe |
| ack_data | input | 8 | Pending bits to clear; bit 0 is the timer event |
| mask_we | input | 1 | One-cycle mask write strobe |
| mask_data | input | 8 | New mask value |
| ext_evt | input | 8 | Event set pulses from other sources |
| count | output | 32 | Current count (read port) |
| pending | output | 8 | Pending event bits |
| mask | output | 8 | Event mask |
| frozen | output | 1 | High while the counter is stopped |
| evt_avail | output | 1 | Some pending bit is enabled by the mask |

## Verification
Loads, ticks, freezes, acknowledges, mask writes and event pulses each reach count, pending, mask and frozen at the first rising edge after the strobe is sampled. evt_avail follows the registered pending and mask values with no further delay. The bench drives every strobe for one cycle just after a rising edge and reads the outputs one time unit after the next edge, so each result is sampled in the cycle it becomes due. Cases where two strobes share a cycle (load with tick, tick with acknowledge) are driven in a single cycle, so the priority rules are checked on the edge where they apply.

// File: rtl/dectmr_pkg.sv
package dectmr_pkg;

  // Run state of the counter
  typedef enum logic {
    ST_RUN    = 1'b0,
    ST_FROZEN = 1'b1
  } run_st_e;

endpackage

// File: rtl/dectmr_counter.sv
module dectmr_counter
  import dectmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_opt,
  input  logic [CNT_W-1:0] tb_lo,
  input  logic             tick_en,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             freeze_req,
  output logic [CNT_W-1:0] cnt_o,
  output logic             frozen_o,
  output logic             underflow_o
);

  // One step down; the top bit is the borrow out of the count width
  function automatic logic [CNT_W:0] step_down(input logic [CNT_W-1:0] v);
    return {1'b0, v} - {{CNT_W{1'b0}}, 1'b1};
  endfunction

  // Reset count chosen by the option input
  function automatic logic [CNT_W-1:0] seed_val(input logic opt, input logic [CNT_W-1:0] tb);
    return opt ? ~tb : '0;
  endfunction

  run_st_e          st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   stepped;
  logic             running;
  logic             tick_apply;
  logic             freeze_take;

  assign stepped     = step_down(cnt_q);
  assign running     = (st_q == ST_RUN);
  assign freeze_take = freeze_req & running & ~load_en;
  assign tick_apply  = tick_en & ~load_en & running & ~freeze_req;
  assign underflow_o = tick_apply & stepped[CNT_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= seed_val(sync_opt, tb_lo);
      st_q  <= ST_RUN;
    end else if (load_en) begin
      cnt_q <= load_val;
      st_q  <= ST_RUN;
    end else begin
      if (freeze_take) st_q <= ST_FROZEN;
      if (tick_apply)  cnt_q <= stepped[CNT_W-1:0];
    end
  end

  assign cnt_o    = cnt_q;
  assign frozen_o = (st_q == ST_FROZEN);

  // R1: reset value selected by the option
  assert_reset_seed_R1: assert property (@(posedge clk)
    !rst_n |=> (cnt_q == ($past(sync_opt) ? ~$past(tb_lo) : '0)) && st_q == ST_RUN);

  // R2: load takes the value and restarts
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> cnt_q == $past(load_val) && st_q == ST_RUN);

  // R3: a running tick decrements by one
  assert_tick_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !load_en && st_q == ST_RUN && !freeze_req) |=> cnt_q == $past(cnt_q) - 1'b1);

  // R6: freeze captures the present count
  assert_freeze_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_req && !load_en && st_q == ST_RUN) |=> st_q == ST_FROZEN && $stable(cnt_q));

  // R7 and R8: without a load the frozen state and count persist
  assert_frozen_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FROZEN && !load_en) |=> st_q == ST_FROZEN && $stable(cnt_q));

  // R9: load beats a concurrent tick
  assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && tick_en) |=> cnt_q == $past(load_val));

endmodule

// File: rtl/dectmr_events.sv
module dectmr_events #(
  parameter int EVT_W  = 8,
  parameter int TM_BIT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             underflow,
  input  logic [EVT_W-1:0] ext_evt,
  input  logic             ack_en,
  input  logic [EVT_W-1:0] ack_data,
  input  logic             mask_we,
  input  logic [EVT_W-1:0] mask_data,
  input  logic             frozen,
  output logic             freeze_req,
  output logic [EVT_W-1:0] pend_o,
  output logic [EVT_W-1:0] mask_o,
  output logic             avail_o
);

  // Collect new events, then drop the acknowledged ones
  function automatic logic [EVT_W-1:0] collect_then_clear(
    input logic [EVT_W-1:0] cur,
    input logic [EVT_W-1:0] fresh,
    input logic             do_ack,
    input logic [EVT_W-1:0] clr
  );
    return (cur | fresh) & ~(do_ack ? clr : '0);
  endfunction

  logic [EVT_W-1:0] pend_q;
  logic [EVT_W-1:0] mask_q;
  logic [EVT_W-1:0] set_vec;

  for (genvar i = 0; i < EVT_W; i++) begin : g_set
    if (i == TM_BIT) begin : g_tm
      assign set_vec[i] = ext_evt[i] | underflow;
    end else begin : g_ext
      assign set_vec[i] = ext_evt[i];
    end
  end

  // Acknowledging a masked-off timer event stops a running counter
  assign freeze_req = ack_en & ack_data[TM_BIT] & ~mask_q[TM_BIT] & ~frozen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= collect_then_clear(pend_q, set_vec, ack_en, ack_data);
      if (mask_we) mask_q <= mask_data;
    end
  end

  assign pend_o  = pend_q;
  assign mask_o  = mask_q;
  assign avail_o = |(pend_q & mask_q);

  // R4: an underflow that is not acknowledged becomes pending
  assert_uf_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !(ack_en && ack_data[TM_BIT])) |=> pend_q[TM_BIT]);

  // R5: acknowledged bits are clear afterwards
  assert_ack_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_en |=> (pend_q & $past(ack_data)) == '0);

  // R11: without an acknowledge no pending bit is lost
  assert_pend_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_en |=> (pend_q & $past(pend_q)) == $past(pend_q));

  // R10: mask write takes effect on the next edge
  assert_mask_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> mask_q == $past(mask_data));

  // R12: with the timer mask bit set no freeze is requested
  assert_no_freeze_masked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q[TM_BIT] |-> !freeze_req);

endmodule

// File: rtl/freeze_dec_timer.sv
module freeze_dec_timer #(
  parameter int CNT_W  = 32,
  parameter int EVT_W  = 8,
  parameter int TM_BIT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_opt,
  input  logic [CNT_W-1:0] timebase_lo,
  input  logic             tick_en,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_data,
  input  logic             ack_en,
  input  logic [EVT_W-1:0] ack_data,
  input  logic             mask_we,
  input  logic [EVT_W-1:0] mask_data,
  input  logic [EVT_W-1:0] ext_evt,
  output logic [CNT_W-1:0] count,
  output logic [EVT_W-1:0] pending,
  output logic [EVT_W-1:0] mask,
  output logic             frozen,
  output logic             evt_avail
);

  // Named internal events shared between the two halves
  logic underflow_w;
  logic freeze_req_w;
  logic frozen_w;

  dectmr_counter #(.CNT_W(CNT_W)) u_counter (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_opt    (sync_opt),
    .tb_lo       (timebase_lo),
    .tick_en     (tick_en),
    .load_en     (load_en),
    .load_val    (load_data),
    .freeze_req  (freeze_req_w),
    .cnt_o       (count),
    .frozen_o    (frozen_w),
    .underflow_o (underflow_w)
  );

  dectmr_events #(.EVT_W(EVT_W), .TM_BIT(TM_BIT)) u_events (
    .clk        (clk),
    .rst_n      (rst_n),
    .underflow  (underflow_w),
    .ext_evt    (ext_evt),
    .ack_en     (ack_en),
    .ack_data   (ack_data),
    .mask_we    (mask_we),
    .mask_data  (mask_data),
    .frozen     (frozen_w),
    .freeze_req (freeze_req_w),
    .pend_o     (pending),
    .mask_o     (mask),
    .avail_o    (evt_avail)
  );

  assign frozen = frozen_w;

  // R7: no timer event can arise while frozen
  assert_no_uf_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frozen_w |-> !underflow_w);

endmodule

// File: tb/freeze_dec_timer_bench.sv
module freeze_dec_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_opt = 1'b0;
  logic [31:0] timebase_lo = '0;
  logic        tick_en = 1'b0;
  logic        load_en = 1'b0;
  logic [31:0] load_data = '0;
  logic        ack_en = 1'b0;
  logic [7:0]  ack_data = '0;
  logic        mask_we = 1'b0;
  logic [7:0]  mask_data = '0;
  logic [7:0]  ext_evt = '0;
  logic [31:0] count;
  logic [7:0]  pending;
  logic [7:0]  mask;
  logic        frozen;
  logic        evt_avail;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  freeze_dec_timer u_freeze_dec_timer (
    .clk(clk), .rst_n(rst_n), .sync_opt(sync_opt), .timebase_lo(timebase_lo),
    .tick_en(tick_en), .load_en(load_en), .load_data(load_data),
    .ack_en(ack_en), .ack_data(ack_data), .mask_we(mask_we), .mask_data(mask_data),
    .ext_evt(ext_evt), .count(count), .pending(pending), .mask(mask),
    .frozen(frozen), .evt_avail(evt_avail)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Advance one edge and settle one time unit after it
  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic do_load(input logic [31:0] v);
    load_en = 1'b1; load_data = v; cyc(); load_en = 1'b0;
  endtask

  task automatic do_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1; cyc(); tick_en = 1'b0;
    end
  endtask

  task automatic do_ack(input logic [7:0] v);
    ack_en = 1'b1; ack_data = v; cyc(); ack_en = 1'b0;
  endtask

  task automatic do_mask(input logic [7:0] v);
    mask_we = 1'b1; mask_data = v; cyc(); mask_we = 1'b0;
  endtask

  task automatic do_ext(input logic [7:0] v);
    ext_evt = v; cyc(); ext_evt = '0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; sync_opt = 1'b1; timebase_lo = 32'h1234_5678;
    cyc(); cyc();
    chk("R1 count inverted timebase", count, 32'hEDCB_A987);
    chk("R1 pending", {24'd0, pending}, 32'd0);
    chk("R1 mask", {24'd0, mask}, 32'd0);
    chk("R1 frozen", {31'd0, frozen}, 32'd0);
    sync_opt = 1'b0; cyc();
    chk("R1 count zero option", count, 32'd0);
    rst_n = 1'b1; cyc();
  endtask

  task automatic t_load_tick();
    do_load(32'd100);
    chk("R2 load", count, 32'd100);
    do_ticks(5);
    chk("R3 five ticks", count, 32'd95);
    cyc(); cyc();
    chk("R3 idle hold", count, 32'd95);
    do_ticks(1); cyc(); do_ticks(1);
    chk("R3 spaced ticks", count, 32'd93);
  endtask

  task automatic t_underflow();
    do_load(32'd2);
    do_ticks(2);
    chk("R4 at zero no event", {24'd0, pending}, 32'd0);
    do_ticks(1);
    chk("R4 wrap", count, 32'hFFFF_FFFF);
    chk("R4 timer pending", {31'd0, pending[0]}, 32'd1);
    chk("R10 masked off avail", {31'd0, evt_avail}, 32'd0);
    do_mask(8'h01);
    chk("R10 avail after mask", {31'd0, evt_avail}, 32'd1);
    do_ack(8'h01);
    chk("R5 ack clears timer", {24'd0, pending}, 32'd0);
    chk("R10 avail drops", {31'd0, evt_avail}, 32'd0);
    chk("R12 no freeze when masked", {31'd0, frozen}, 32'd0);
    do_mask(8'h00);
  endtask

  task automatic t_ack_exact();
    do_ext(8'hA6);
    chk("R10 ext sets pending", {24'd0, pending}, 32'h0000_00A6);
    do_ack(8'h22);
    chk("R5 exact clear", {24'd0, pending}, 32'h0000_0084);
    do_mask(8'h04);
    chk("R10 avail one enabled", {31'd0, evt_avail}, 32'd1);
    do_mask(8'h80);
    do_ack(8'h04);
    chk("R5 clear bit2", {24'd0, pending}, 32'h0000_0080);
    chk("R10 avail after ack", {31'd0, evt_avail}, 32'd1);
    do_ack(8'hFE);
    chk("R5 clear rest", {24'd0, pending}, 32'd0);
    do_mask(8'h00);
  endtask

  task automatic t_freeze();
    do_load(32'd50);
    do_ticks(3);
    do_ack(8'h01);
    chk("R6 frozen set", {31'd0, frozen}, 32'd1);
    chk("R6 count held", count, 32'd47);
    do_ticks(10);
    chk("R7 ticks ignored", count, 32'd47);
    do_load(32'd0);
    chk("R2 load unfreezes", {31'd0, frozen}, 32'd0);
    do_ack(8'h01);
    do_ticks(3);
    chk("R7 no wrap frozen", count, 32'd0);
    chk("R7 no event frozen", {24'd0, pending}, 32'd0);
    do_mask(8'h01);
    chk("R8 mask keeps frozen", {31'd0, frozen}, 32'd1);
    do_ticks(1);
    chk("R8 still held", count, 32'd0);
    do_load(32'd5);
    chk("R8 load resumes", {31'd0, frozen}, 32'd0);
    do_ticks(1);
    chk("R8 counts again", count, 32'd4);
    do_mask(8'h00);
  endtask

  task automatic t_masked_ack();
    do_mask(8'h01);
    do_load(32'd10);
    do_ack(8'h01);
    chk("R12 no freeze", {31'd0, frozen}, 32'd0);
    do_ticks(1);
    chk("R12 keeps counting", count, 32'd9);
    do_mask(8'h00);
  endtask

  task automatic t_collision();
    load_en = 1'b1; load_data = 32'd20; tick_en = 1'b1;
    cyc();
    load_en = 1'b0; tick_en = 1'b0;
    chk("R9 load wins", count, 32'd20);
    do_ticks(1);
    chk("R9 next tick", count, 32'd19);
  endtask

  task automatic t_load_keeps();
    do_load(32'd0);
    do_ticks(1);
    do_load(32'd7);
    chk("R11 pending kept", {31'd0, pending[0]}, 32'd1);
    chk("R11 load value", count, 32'd7);
    do_mask(8'h01);
    do_ack(8'h01);
    chk("R11 cleanup", {24'd0, pending}, 32'd0);
  endtask

  task automatic t_ack_with_uf();
    do_load(32'd0);
    tick_en = 1'b1; ack_en = 1'b1; ack_data = 8'h01;
    cyc();
    tick_en = 1'b0; ack_en = 1'b0;
    chk("R5 same-cycle event cleared", {24'd0, pending}, 32'd0);
    chk("R4 wrap with ack", count, 32'hFFFF_FFFF);
    chk("R12 masked no freeze", {31'd0, frozen}, 32'd0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset();
    t_load_tick();
    t_underflow();
    t_ack_exact();
    t_freeze();
    t_masked_ack();
    t_collision();
    t_load_keeps();
    t_ack_with_uf();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule